// File: doc/BRIEF.md
# SCL Clock Synchronization Generator

This block produces the serial clock for a two-wire bus master whose clock line is a wired-AND shared with other masters and with targets that stretch the clock. It never drives the line high. It asserts an open-drain enable to pull SCL low, and drops that enable to let the pull-up raise the line. It reads the real line level back through a short synchronizer with edge detection, so its timing follows whichever device on the bus is slowest.

A single `xfer_req` strobe starts a burst of nine clock pulses: eight data bits and the acknowledge. The same burst serves address, write and read bytes. Each low phase is timed against a programmable low period. Each high phase is timed against a programmable high period. If another device pulls the line low early, the block drops its high count and starts a fresh low count from the edge it saw. If a device holds the line low after the block has released it, the block waits as long as that takes before it counts any high time. After the ninth pulse the block raises `xfer_done` for one cycle and keeps holding SCL low, which stretches the clock until software is ready for the next byte.

The request and done pins are plain control strobes with no back-pressure. A request is only taken while no burst is running. Periods are in system clock cycles and are read when a phase starts.

Top module: `scl_sync_gen`

## Requirements
- R1: After reset `scl_oe` and `xfer_done` are 0, and SCL stays released until `xfer_req` is sampled high.
- R2: Every low phase the block itself starts, whether on an accepted request or when its high count expires, keeps `scl_oe` at 1 for exactly L cycles. L is the effective low period. For a request accepted while parked, the count starts at the edge that samples the request.
- R3: When no other device holds SCL, the block keeps SCL released for exactly H cycles. H is the effective high period. Put another way, it drives low again on the (H-1)th clock edge after the first edge that captures SCL high.
- R4: If SCL stays low after the block releases it, `scl_oe` stays 0 with no time limit and no high time is counted. Once the line rises, the block drives low again on the (H-1)th edge after the first edge that captures SCL high.
- R5: If another device pulls SCL low during the high count, `scl_oe` goes to 1 on the second edge after the first edge that captures SCL low. The following low phase lasts L cycles, counted from that edge.
- R6: `low_period` and `high_period` are 16-bit unsigned cycle counts. Any value below 4, zero included, acts as 4.
- R7: One accepted request produces exactly nine release phases, which are nine SCL high pulses.
- R8: `xfer_done` is 1 for exactly one cycle per burst. That cycle is the one in which `scl_oe` returns to 1 after the ninth high pulse.
- R9: After a burst, `scl_oe` stays 1 until the next `xfer_req`.
- R10: `xfer_req` pulses that arrive while a burst is in progress are ignored, and the burst still has nine pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Start a nine-pulse burst (taken only when idle or parked) |
| xfer_done | output | 1 | One-cycle strobe at the end of the ninth pulse |
| low_period | input | 16 | Low phase length in system cycles (minimum 4) |
| high_period | input | 16 | High phase length in system cycles (minimum 4) |
| scl_in | input | 1 | Level read back from the SCL pad |
| scl_oe | output | 1 | Open-drain enable: 1 pulls SCL low, 0 releases |

## Verification
Two situations are hard to create from the ports: a second device that keeps the line low after the block has released it, and a second device that cuts the high phase short. Both depend on the exact cycle the synchronizer sees the line. The bench places a modelled second device on the wired-AND line. At random, it either asserts a hold during the block's own low phase and keeps it well past the release, once for hundreds of cycles, or it pulls the line low partway through a high phase once the high count is certainly running. The bench then measures every phase length in cycles against the period settings.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARK  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HWAIT = 3'd3,
    ST_HIGH  = 3'd4
  } scl_state_t;

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  // chain[STAGES-1] is the synchronized level, chain[STAGES] the edge reference
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/scl_bit_counter.sv
module scl_bit_counter #(
  parameter int BURST = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);

  localparam int CW = $clog2(BURST + 1);
  localparam logic [CW-1:0] LAST_V = CW'(BURST - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_V);

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
  import scl_pkg::*;
#(
  parameter int PERIOD_W    = 16,
  parameter int BURST_LEN   = 9,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_req,
  output logic                xfer_done,
  input  logic [PERIOD_W-1:0] low_period,
  input  logic [PERIOD_W-1:0] high_period,
  input  logic                scl_in,
  output logic                scl_oe
);

  // Cycles from own release to the first HIGH cycle, plus the cycle the count ends on
  localparam int HI_ADJ = SYNC_STAGES + 2;
  localparam int FLOOR  = (MIN_PERIOD > HI_ADJ) ? MIN_PERIOD : HI_ADJ;
  localparam logic [PERIOD_W-1:0] FLOOR_V  = PERIOD_W'(FLOOR);
  localparam logic [PERIOD_W-1:0] HI_ADJ_V = PERIOD_W'(HI_ADJ);

  scl_state_t state, state_nxt;
  logic oe_nxt, done_nxt;
  logic scl_rise, scl_fall;
  logic tmr_load, tmr_expired;
  logic [PERIOD_W-1:0] tmr_val, low_eff, high_eff, low_load, high_load;
  logic bit_clr, bit_step, bit_last;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (scl_in),
    .rise (scl_rise),
    .fall (scl_fall)
  );

  scl_phase_timer #(.W(PERIOD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  scl_bit_counter #(.BURST(BURST_LEN)) u_bits (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(bit_clr),
    .step (bit_step),
    .last (bit_last)
  );

  always_comb begin
    low_eff   = (low_period  < FLOOR_V) ? FLOOR_V : low_period;
    high_eff  = (high_period < FLOOR_V) ? FLOOR_V : high_period;
    low_load  = low_eff - 1'b1;
    // synchronizer latency is taken out of the high count
    high_load = high_eff - HI_ADJ_V;
  end

  always_comb begin
    state_nxt = state;
    oe_nxt    = scl_oe;
    done_nxt  = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = low_load;
    bit_clr   = 1'b0;
    bit_step  = 1'b0;
    unique case (state)
      ST_IDLE, ST_PARK: begin
        if (xfer_req) begin
          state_nxt = ST_LOW;
          oe_nxt    = 1'b1;
          tmr_load  = 1'b1;
          bit_clr   = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          state_nxt = ST_HWAIT;
          oe_nxt    = 1'b0;
        end
      end
      ST_HWAIT: begin
        // line may be held by a slower device: wait for the seen rise
        if (scl_rise) begin
          state_nxt = ST_HIGH;
          tmr_load  = 1'b1;
          tmr_val   = high_load;
        end
      end
      ST_HIGH: begin
        if (scl_fall || tmr_expired) begin
          bit_step = 1'b1;
          oe_nxt   = 1'b1;
          if (bit_last) begin
            state_nxt = ST_PARK;
            done_nxt  = 1'b1;
          end else begin
            state_nxt = ST_LOW;
            tmr_load  = 1'b1;
          end
        end
      end
      default: begin
        state_nxt = ST_IDLE;
        oe_nxt    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      scl_oe    <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      state     <= state_nxt;
      scl_oe    <= oe_nxt;
      xfer_done <= done_nxt;
    end
  end

endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk
  import scl_pkg::*;
#(
  parameter int BURST   = 9,
  parameter int MIN_LEN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_req,
  input logic       xfer_done,
  input logic       scl_oe,
  input scl_state_t state
);

  logic        oe_q;
  int unsigned run_cnt;
  int unsigned falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      run_cnt <= 32'hFFFF;
      falls   <= 0;
    end else begin
      oe_q <= scl_oe;
      if (scl_oe != oe_q)         run_cnt <= 1;
      else if (run_cnt < 32'hFFFF) run_cnt <= run_cnt + 1;
      if ((state == ST_IDLE || state == ST_PARK) && xfer_req) falls <= 0;
      else if (oe_q && !scl_oe)                               falls <= falls + 1;
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !xfer_req) |=> (state == ST_IDLE && !scl_oe));

  a_r2_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !scl_oe) |-> (run_cnt >= MIN_LEN));

  a_r3_release_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_q && scl_oe) |-> (run_cnt >= MIN_LEN));

  a_r4_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HWAIT) |-> !scl_oe);

  a_r7_nine_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (falls == BURST));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  a_r8_done_with_pull: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (scl_oe && !oe_q));

  a_r9_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARK && !xfer_req) |=> (state == ST_PARK && scl_oe));

endmodule

bind scl_sync_gen scl_sync_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xfer_req (xfer_req),
  .xfer_done(xfer_done),
  .scl_oe   (scl_oe),
  .state    (state)
);

// File: tb/scl_sync_gen_test.sv
`timescale 1ns/1ps
module scl_sync_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_req = 1'b0;
  logic        xfer_done;
  logic [15:0] low_period = 16'd8;
  logic [15:0] high_period = 16'd8;
  logic        scl_oe;
  logic        ext_low = 1'b0;
  logic        scl_line;

  assign scl_line = !scl_oe && !ext_low;

  always #10 clk = ~clk;

  scl_sync_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_req   (xfer_req),
    .xfer_done  (xfer_done),
    .low_period (low_period),
    .high_period(high_period),
    .scl_in     (scl_line),
    .scl_oe     (scl_oe)
  );

  int checks = 0;
  int errors = 0;
  int wd = 0;
  bit finished = 0;

  // bench model state
  int effL, effH;
  string tagL, tagH;
  int lo_run, hi_run, pull_ctr, stretch_ctr, stretch_len;
  int pulses, done_cnt;
  bit oe_p = 0, seen_high, ext_held, stretch_on = 0, pull_on = 0, in_burst = 0;
  int s_pct, s_max, p_pct, n_pct;

  function automatic int eff(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd >= 190000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    bit oe, d, ln;
    @(negedge clk);
    oe = scl_oe; d = xfer_done; ln = scl_line;
    if (pull_ctr >= 0) pull_ctr++;
    if (oe && !oe_p) begin
      if (seen_high) begin
        pulses++;
        if (pull_ctr >= 0) chk(pull_ctr == 3, "R5", pull_ctr, 3);
        else if (ext_held) chk(hi_run == effH - 1, (tagH == "R6") ? "R6" : "R4", hi_run, effH - 1);
        else chk(hi_run == effH, tagH, hi_run, effH);
      end
      lo_run = 1;
      pull_ctr = -1;
      if (in_burst && !pull_on && pulses < 9 && ($urandom % 100) < s_pct) begin
        stretch_on = 1;
        stretch_len = 1 + ($urandom % s_max);
        stretch_ctr = 0;
      end
    end else if (!oe && oe_p) begin
      chk(lo_run == effL, tagL, lo_run, effL);
      seen_high = 1;
      hi_run = ln ? 1 : 0;
      ext_held = !ln;
    end else if (oe) begin
      lo_run++;
    end else if (ln) begin
      hi_run++;
    end
    if (d) begin
      done_cnt++;
      chk(oe && !oe_p, "R8", oe, 1);
      chk(pulses == 9, "R7", pulses, 9);
    end
    chk(pulses <= 9, "R7", pulses, 9);
    // drive the modelled second device and the request line
    xfer_req = 1'b0;
    if (stretch_on && !oe) begin
      stretch_ctr++;
      if (stretch_ctr >= stretch_len) stretch_on = 0;
    end
    if (pull_on && pull_ctr >= 2) pull_on = 0;
    if (in_burst && !oe && ln && !stretch_on && pull_ctr < 0 && hi_run >= 4 &&
        hi_run + 5 <= effH && ($urandom % 100) < p_pct) begin
      pull_on = 1;
      pull_ctr = 0;
    end
    if (in_burst && pulses >= 1 && pulses < 8 && ($urandom % 100) < n_pct) xfer_req = 1'b1;
    ext_low = stretch_on | pull_on;
    oe_p = oe;
  endtask

  task automatic burst(input int lo, input int hi, input int sp, input int sm,
                       input int pp, input int np);
    int limit;
    low_period = lo[15:0];
    high_period = hi[15:0];
    effL = eff(lo); effH = eff(hi);
    tagL = (lo < 4) ? "R6" : "R2";
    tagH = (hi < 4) ? "R6" : "R3";
    s_pct = sp; s_max = (sm < 1) ? 1 : sm; p_pct = pp; n_pct = np;
    pulses = 0; done_cnt = 0; seen_high = 0; lo_run = 0; pull_ctr = -1;
    in_burst = 1;
    xfer_req = 1'b1;
    limit = 9 * (effL + effH + s_max + 8) + 50;
    for (int i = 0; i < limit && done_cnt == 0; i++) step();
    chk(done_cnt == 1, "R8", done_cnt, 1);
    in_burst = 0;
    for (int i = 0; i < 12; i++) begin
      step();
      chk(scl_oe == 1'b1, "R9", scl_oe, 1);
    end
    chk(done_cnt == 1, "R8", done_cnt, 1);
    chk(pulses == 9, (np > 0) ? "R10" : "R7", pulses, 9);
  endtask

  initial begin
    void'($urandom(32'h5CA1_0042));
    repeat (3) @(negedge clk);
    chk(!scl_oe && !xfer_done, "R1", {scl_oe, xfer_done}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(!scl_oe && !xfer_done, "R1", {scl_oe, xfer_done}, 0);
    end
    // directed corners
    burst(0, 2, 0, 1, 0, 0);        // clamped both ways
    burst(10, 12, 0, 1, 0, 0);      // plain
    burst(6, 20, 100, 300, 0, 0);   // long holds after release
    burst(7, 20, 0, 1, 70, 0);      // early pulls during high
    burst(9, 11, 0, 1, 0, 40);      // requests mid-burst
    burst(3, 1, 50, 10, 0, 0);      // clamp with holds
    burst(200, 30, 20, 40, 40, 10); // long low
    // constrained random
    for (int b = 0; b < 30; b++)
      burst($urandom % 41, $urandom % 41, 30, 40, 30, 10);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule